// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block stands in for the status side of a byte-wide flash array while an internal program or erase runs. A start pulse begins an operation of a given kind: byte program, sector erase or chip erase. The pulse marks the rising edge of the last write strobe of the command sequence. From the next clock on, reads return a status byte instead of array contents. Two toggle bits in that byte answer different questions. Bit 6 says whether the operation is actively running. Bit 2 says whether the read address sits in a sector chosen for erasure, whether that erase is running or suspended.

The array is reduced to one blank/non-blank flag per byte. A blank byte reads `8'hFF` and a written byte reads `8'h00`. The internal pulse counter is a cycle counter. A normal operation completes after `OP_CYCLES` active cycles. If the counter reaches `PULSE_LIMIT`, the block enters a timeout state that raises bit 5. This happens when a program targets a byte that is already written: that program is locked out and never completes.

The controller has five states. **IDLE**: array reads. **PROG**: byte program running. **ERASE**: sector or chip erase running. **SUSP**: erase suspended. **TMO**: limit exceeded.

The transitions are:
- *accept_prog*: IDLE→PROG.
- *accept_erase*: IDLE→ERASE.
- *prog_done*: PROG→IDLE.
- *erase_done*: ERASE→IDLE.
- *hold*: ERASE→SUSP.
- *release*: SUSP→ERASE.
- *overrun*: PROG or ERASE→TMO, when the counter reaches the limit.
- *clear*: TMO→IDLE, on the reset command.

Top module: `flash_opstat_gen`

## Requirements
- R1: After reset `rd_data` is `8'h00`, the state is IDLE, and every byte reads as blank (`8'hFF`).
- R2: A start in IDLE with `op_kind`=0 programs `prog_addr` when the byte is blank. After `OP_CYCLES` cycles the block is back in IDLE and that byte reads `8'h00`.
- R3: The status byte carries bit 6 = busy toggle, bit 5 = timeout and bit 2 = select toggle, with all other bits 0. Both toggles are cleared by an accepted start. Bit 6 inverts after every read in PROG, ERASE or TMO.
- R4: Bit 2 inverts after every read whose sector (upper address bits) is selected for erasure, in both ERASE and SUSP. Reads of other sectors leave it unchanged.
- R5: `oe_rd` and `ce_rd` each strobe a read. Both high in one cycle count as a single read.
- R6: `suspend` in ERASE enters SUSP and the cycle counter stops. In SUSP, bit 6 holds and reads outside the selected sectors return array data. `resume` returns to ERASE.
- R7: `op_kind`=1 erases the sectors set in `erase_mask`. `op_kind`=2 erases every sector and ignores the mask. On completion only those sectors read blank. `op_kind`=3 is not accepted.
- R8: Programming a non-blank byte never completes, and bit 6 keeps inverting on reads. Once `PULSE_LIMIT` active cycles have elapsed, the block is in TMO and status reads show bit 5 = 1.
- R9: In TMO, only status reads are served, and start and suspend are ignored. `reset_cmd` returns to IDLE with array reads. `reset_cmd` has no effect in any other state.
- R10: In IDLE reads return array data, and repeated reads give the same value.
- R11: While busy, a start is ignored. In PROG, `suspend` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Final command strobe, one cycle |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase |
| erase_mask | input | NSEC | Sectors to erase for `op_kind`=1 |
| prog_addr | input | AW | Byte address to program |
| suspend | input | 1 | Erase suspend command |
| resume | input | 1 | Erase resume command |
| reset_cmd | input | 1 | Reset command, leaves timeout |
| oe_rd | input | 1 | Read strobe, output-enable form |
| ce_rd | input | 1 | Read strobe, chip-enable form |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Registered read result, valid the cycle after a strobe |

## Verification
The bench builds the block with four sectors of four bytes (`NSEC`=4, `SEC_AW`=2), `OP_CYCLES`=8 and `PULSE_LIMIT`=24. With these values, every address can be swept during a single suspended erase. The sweep compares the per-address choice between status and array data, and the bit 2 sequence, against a bench model. The short limit lets a locked-out program reach the timeout within a few dozen cycles. The bench then checks how start, suspend and the reset command behave there.

// File: rtl/fos_pkg.sv
package fos_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SUSP  = 3'd3,
        ST_TMO   = 3'd4
    } fos_state_e;

    localparam logic [1:0] KIND_PROG  = 2'd0;
    localparam logic [1:0] KIND_SECT  = 2'd1;
    localparam logic [1:0] KIND_CHIP  = 2'd2;

    localparam int BIT_BUSY_TGL = 6;
    localparam int BIT_TIMEOUT  = 5;
    localparam int BIT_SEL_TGL  = 2;

    localparam logic [7:0] BYTE_BLANK   = 8'hFF;
    localparam logic [7:0] BYTE_WRITTEN = 8'h00;

endpackage

// File: rtl/fos_blank_map.sv
module fos_blank_map #(
    parameter int NSEC   = 4,
    parameter int SEC_AW = 4,
    localparam int DEPTH = NSEC << SEC_AW,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mark_en,
    input  logic [AW-1:0]   mark_addr,
    input  logic            wipe_en,
    input  logic [NSEC-1:0] wipe_mask,
    input  logic [AW-1:0]   look_a,
    input  logic [AW-1:0]   look_b,
    output logic            blank_a,
    output logic            blank_b
);

    logic [DEPTH-1:0] blank_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                blank_q[i] <= 1'b1;
            end else if (wipe_en && wipe_mask[i >> SEC_AW]) begin
                blank_q[i] <= 1'b1;
            end else if (mark_en && (mark_addr == AW'(i))) begin
                blank_q[i] <= 1'b0;
            end
        end
    end

    assign blank_a = blank_q[look_a];
    assign blank_b = blank_q[look_b];

endmodule

// File: rtl/fos_op_fsm.sv
module fos_op_fsm
    import fos_pkg::*;
#(
    parameter int NSEC        = 4,
    parameter int AW          = 6,
    parameter int OP_CYCLES   = 12,
    parameter int PULSE_LIMIT = 32,
    localparam int CW         = $clog2(PULSE_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op_kind,
    input  logic [NSEC-1:0] erase_mask,
    input  logic [AW-1:0]   prog_addr,
    input  logic            tgt_blank,
    input  logic            suspend,
    input  logic            resume,
    input  logic            reset_cmd,
    output fos_state_e      st,
    output logic [NSEC-1:0] sel_mask,
    output logic [AW-1:0]   tgt_addr,
    output logic [CW-1:0]   cnt,
    output logic            start_ok,
    output logic            prog_done,
    output logic            erase_done
);

    fos_state_e st_q, st_n;
    logic [CW-1:0]   cnt_q;
    logic [NSEC-1:0] sel_q;
    logic [AW-1:0]   tgt_q;
    logic            lock_q;
    logic            kind_ok;
    logic            at_limit;
    logic            at_done;

    assign kind_ok  = (op_kind != 2'd3);
    assign at_limit = (cnt_q == CW'(PULSE_LIMIT - 1));
    assign at_done  = (cnt_q == CW'(OP_CYCLES - 1));

    // next-state decision
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start && kind_ok) begin
                    st_n = (op_kind == KIND_PROG) ? ST_PROG : ST_ERASE;
                end
            end
            ST_PROG: begin
                if (at_limit) begin
                    st_n = ST_TMO;
                end else if (!lock_q && at_done) begin
                    st_n = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (at_limit) begin
                    st_n = ST_TMO;
                end else if (at_done) begin
                    st_n = ST_IDLE;
                end else if (suspend) begin
                    st_n = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (resume) begin
                    st_n = ST_ERASE;
                end
            end
            ST_TMO: begin
                if (reset_cmd) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    // operation context: pulse counter, selection, target, lockout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sel_q  <= '0;
            tgt_q  <= '0;
            lock_q <= 1'b0;
        end else if (st_q == ST_IDLE && st_n != ST_IDLE) begin
            cnt_q  <= '0;
            tgt_q  <= prog_addr;
            lock_q <= (op_kind == KIND_PROG) && !tgt_blank;
            unique case (op_kind)
                KIND_SECT: sel_q <= erase_mask;
                KIND_CHIP: sel_q <= '1;
                default:   sel_q <= '0;
            endcase
        end else if ((st_q == ST_PROG || st_q == ST_ERASE) && st_n == st_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        st         = st_q;
        sel_mask   = sel_q;
        tgt_addr   = tgt_q;
        cnt        = cnt_q;
        start_ok   = (st_q == ST_IDLE) && (st_n != ST_IDLE);
        prog_done  = (st_q == ST_PROG) && (st_n == ST_IDLE);
        erase_done = (st_q == ST_ERASE) && (st_n == ST_IDLE);
    end

endmodule

// File: rtl/fos_toggle_unit.sv
module fos_toggle_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv_busy,
    input  logic adv_sel,
    output logic t_busy,
    output logic t_sel
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_busy <= 1'b0;
            t_sel  <= 1'b0;
        end else if (clr) begin
            t_busy <= 1'b0;
            t_sel  <= 1'b0;
        end else begin
            if (adv_busy) t_busy <= ~t_busy;
            if (adv_sel)  t_sel  <= ~t_sel;
        end
    end

endmodule

// File: rtl/flash_opstat_gen.sv
module flash_opstat_gen
    import fos_pkg::*;
#(
    parameter int NSEC        = 4,
    parameter int SEC_AW      = 4,
    parameter int OP_CYCLES   = 12,
    parameter int PULSE_LIMIT = 32,
    localparam int AW         = $clog2(NSEC << SEC_AW),
    localparam int SECW       = $clog2(NSEC),
    localparam int CW         = $clog2(PULSE_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op_kind,
    input  logic [NSEC-1:0] erase_mask,
    input  logic [AW-1:0]   prog_addr,
    input  logic            suspend,
    input  logic            resume,
    input  logic            reset_cmd,
    input  logic            oe_rd,
    input  logic            ce_rd,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data
);

    fos_state_e      st_q;
    logic [NSEC-1:0] sel_mask;
    logic [AW-1:0]   tgt_addr;
    logic [CW-1:0]   cnt;
    logic            start_ok, prog_done, erase_done;
    logic            tgt_blank, rd_blank;
    logic            t_busy, t_sel;
    logic            rd_fire, in_sel, running, status_mode;
    logic [SECW-1:0] rd_sec;
    logic [7:0]      stat_byte, arr_byte;

    fos_op_fsm #(
        .NSEC(NSEC), .AW(AW), .OP_CYCLES(OP_CYCLES), .PULSE_LIMIT(PULSE_LIMIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .erase_mask(erase_mask), .prog_addr(prog_addr), .tgt_blank(tgt_blank),
        .suspend(suspend), .resume(resume), .reset_cmd(reset_cmd),
        .st(st_q), .sel_mask(sel_mask), .tgt_addr(tgt_addr), .cnt(cnt),
        .start_ok(start_ok), .prog_done(prog_done), .erase_done(erase_done)
    );

    fos_blank_map #(.NSEC(NSEC), .SEC_AW(SEC_AW)) u_map (
        .clk(clk), .rst_n(rst_n),
        .mark_en(prog_done), .mark_addr(tgt_addr),
        .wipe_en(erase_done), .wipe_mask(sel_mask),
        .look_a(prog_addr), .look_b(rd_addr),
        .blank_a(tgt_blank), .blank_b(rd_blank)
    );

    assign rd_fire     = oe_rd | ce_rd;
    assign rd_sec      = rd_addr[AW-1:SEC_AW];
    assign in_sel      = sel_mask[rd_sec];
    assign running     = (st_q == ST_PROG) || (st_q == ST_ERASE) || (st_q == ST_TMO);
    assign status_mode = running || ((st_q == ST_SUSP) && in_sel);

    fos_toggle_unit u_tgl (
        .clk(clk), .rst_n(rst_n), .clr(start_ok),
        .adv_busy(rd_fire && running),
        .adv_sel(rd_fire && in_sel && ((st_q == ST_ERASE) || (st_q == ST_SUSP))),
        .t_busy(t_busy), .t_sel(t_sel)
    );

    always_comb begin
        stat_byte               = '0;
        stat_byte[BIT_BUSY_TGL] = t_busy;
        stat_byte[BIT_TIMEOUT]  = (st_q == ST_TMO);
        stat_byte[BIT_SEL_TGL]  = t_sel;
        arr_byte                = rd_blank ? BYTE_BLANK : BYTE_WRITTEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_fire) begin
            rd_data <= status_mode ? stat_byte : arr_byte;
        end
    end

endmodule

// File: rtl/fos_checker.sv
module fos_checker
    import fos_pkg::*;
#(
    parameter int PULSE_LIMIT = 32,
    parameter int CW          = 6
) (
    input logic          clk,
    input logic          rst_n,
    input fos_state_e    st,
    input logic [CW-1:0] cnt,
    input logic          start_ok,
    input logic          rd_fire,
    input logic          in_sel,
    input logic          t_busy,
    input logic          t_sel,
    input logic          reset_cmd,
    input logic [7:0]    rd_data
);

    p_busy_flips_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && (st == ST_PROG || st == ST_ERASE)) |=> (t_busy != $past(t_busy)));

    p_outside_sel_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !in_sel && !start_ok) |=> $stable(t_sel));

    p_susp_busy_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |=> $stable(t_busy));

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(PULSE_LIMIT));

    p_tmo_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && st == ST_TMO) |=> rd_data[BIT_TIMEOUT]);

    p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TMO && !reset_cmd) |=> (st == ST_TMO));

    p_idle_busy_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !start_ok) |=> $stable(t_busy));

endmodule

bind flash_opstat_gen fos_checker #(.PULSE_LIMIT(PULSE_LIMIT), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_q), .cnt(cnt), .start_ok(start_ok),
    .rd_fire(rd_fire), .in_sel(in_sel), .t_busy(t_busy), .t_sel(t_sel),
    .reset_cmd(reset_cmd), .rd_data(rd_data)
);

// File: tb/tb_flash_opstat_gen.sv
module tb_flash_opstat_gen;

    localparam int NSEC = 4;
    localparam int SEC_AW = 2;
    localparam int AW = 4;
    localparam int OPC = 8;
    localparam int LIM = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op_kind = '0;
    logic [NSEC-1:0] erase_mask = '0;
    logic [AW-1:0] prog_addr = '0;
    logic suspend = 1'b0, resume = 1'b0, reset_cmd = 1'b0;
    logic oe_rd = 1'b0, ce_rd = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic t6m = 1'b0;
    logic t2m = 1'b0;
    logic [15:0] blank_m = '1;

    always #4 clk = ~clk;

    flash_opstat_gen #(.NSEC(NSEC), .SEC_AW(SEC_AW), .OP_CYCLES(OPC), .PULSE_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .erase_mask(erase_mask), .prog_addr(prog_addr), .suspend(suspend),
        .resume(resume), .reset_cmd(reset_cmd), .oe_rd(oe_rd), .ce_rd(ce_rd),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [1:0] k, input logic [3:0] m, input logic [AW-1:0] a);
        @(negedge clk);
        op_kind = k; erase_mask = m; prog_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // which: 0 suspend, 1 resume, 2 reset command
    task automatic do_cmd(input int which);
        @(negedge clk);
        suspend = (which == 0); resume = (which == 1); reset_cmd = (which == 2);
        @(negedge clk);
        suspend = 1'b0; resume = 1'b0; reset_cmd = 1'b0;
    endtask

    // how: 0 oe only, 1 ce only, 2 both
    task automatic do_read(input logic [AW-1:0] a, input int how, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a; oe_rd = (how != 1); ce_rd = (how != 0);
        @(negedge clk);
        oe_rd = 1'b0; ce_rd = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_stat(input logic [AW-1:0] a, input logic insel, input logic to,
                           input logic flip6, input int how, input string req);
        logic [7:0] d;
        logic [7:0] e;
        do_read(a, how, d);
        e = 8'((int'(t6m) << 6) | (int'(to) << 5) | (int'(t2m) << 2));
        chk(req, d, e);
        if (flip6) t6m = ~t6m;
        if (insel) t2m = ~t2m;
    endtask

    task automatic rd_arr(input logic [AW-1:0] a, input string req);
        logic [7:0] d;
        do_read(a, 0, d);
        chk(req, d, blank_m[a] ? 8'hFF : 8'h00);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset rd_data", rd_data, 8'h00);
        for (int a = 0; a < 16; a++) rd_arr(AW'(a), "R1 blank after reset");

        // R2/R3/R5: program byte 5, reads by oe, ce, both
        do_start(2'd0, 4'h0, 4'd5);
        t6m = 0; t2m = 0;
        rd_stat(4'd5, 0, 0, 1, 0, "R3 prog read oe");
        rd_stat(4'd5, 0, 0, 1, 1, "R5 prog read ce");
        rd_stat(4'd5, 0, 0, 1, 2, "R5 prog read both");
        wait_cyc(OPC + 2);
        blank_m[5] = 1'b0;
        rd_arr(4'd5, "R2 programmed byte");
        rd_arr(4'd4, "R2 neighbour blank");
        rd_arr(4'd5, "R10 idle repeat");

        // R11: suspend and new start ignored during program of byte 9
        do_start(2'd0, 4'h0, 4'd9);
        t6m = 0; t2m = 0;
        do_cmd(0);
        rd_stat(4'd9, 0, 0, 1, 0, "R11 suspend ignored in program");
        do_start(2'd0, 4'h0, 4'd10);
        rd_stat(4'd10, 0, 0, 1, 0, "R11 start ignored while busy");
        wait_cyc(OPC + 2);
        blank_m[9] = 1'b0;
        rd_arr(4'd9, "R2 second program");
        rd_arr(4'd10, "R11 ignored start left byte blank");

        // R4/R6/R7: sector erase of sector 1, suspend, sweep
        do_start(2'd1, 4'b0010, 4'd0);
        t6m = 0; t2m = 0;
        do_cmd(0);
        for (int a = 0; a < 16; a++) begin
            if (a[3:2] == 2'd1) rd_stat(AW'(a), 1, 0, 0, 0, "R6 suspended selected sector");
            else                rd_arr(AW'(a), "R6 suspended other sector array");
        end
        wait_cyc(3 * OPC);
        rd_stat(4'd4, 1, 0, 0, 1, "R6 counter paused in suspend");
        do_cmd(1);
        rd_stat(4'd5, 1, 0, 1, 0, "R4 resumed selected read");
        rd_stat(4'd9, 0, 0, 1, 0, "R4 outside sector keeps bit2");
        wait_cyc(OPC + 2);
        blank_m[7:4] = 4'hF;
        rd_arr(4'd5, "R7 sector erased");
        rd_arr(4'd9, "R7 other sector kept");

        // R7/R9: chip erase ignores mask; reset command ignored while busy
        do_start(2'd2, 4'b0000, 4'd0);
        t6m = 0; t2m = 0;
        do_cmd(2);
        rd_stat(4'd9, 1, 0, 1, 0, "R9 reset ignored in erase");
        rd_stat(4'd0, 1, 0, 1, 2, "R4 chip erase selects all");
        wait_cyc(OPC + 2);
        blank_m = '1;
        for (int a = 0; a < 16; a++) rd_arr(AW'(a), "R7 chip erase blank");

        // R7: op_kind 3 not accepted
        do_start(2'd3, 4'hF, 4'd0);
        rd_arr(4'd2, "R7 invalid kind ignored");

        // R8: lockout
        do_start(2'd0, 4'h0, 4'd3);
        wait_cyc(OPC + 2);
        blank_m[3] = 1'b0;
        do_start(2'd0, 4'h0, 4'd3);
        t6m = 0; t2m = 0;
        rd_stat(4'd3, 0, 0, 1, 0, "R8 locked toggles early");
        rd_stat(4'd3, 0, 0, 1, 0, "R8 locked toggles early 2");
        wait_cyc(LIM + 4);
        rd_stat(4'd3, 0, 1, 1, 0, "R8 timeout flag");
        rd_stat(4'd6, 0, 1, 1, 1, "R8 timeout keeps toggling");
        do_start(2'd0, 4'h0, 4'd6);
        rd_stat(4'd6, 0, 1, 1, 0, "R9 start ignored in timeout");
        do_cmd(0);
        rd_stat(4'd3, 0, 1, 1, 0, "R9 suspend ignored in timeout");
        do_cmd(2);
        rd_arr(4'd3, "R9 reset returns to array reads");
        rd_arr(4'd6, "R9 ignored start left byte blank");
        rd_arr(4'd6, "R10 idle stable");

        summary();
        $finish;
    end

endmodule